// File: doc/BRIEF.md
# Per-Element Saturating Integer Clamp

This block takes one element of an integer result and limits it to the range of the destination element. The producing arithmetic runs ahead of it at the larger of the source and destination widths. It hands over a 66-bit signed intermediate value, which can hold any 64-bit signed or unsigned sum or difference without loss. The destination element width is chosen per element from 8, 16, 32 or 64 bits. The clamp range is either unsigned (0 to 2^w-1) or signed (-2^(w-1) to 2^(w-1)-1). The clamped value leaves the block sign- or zero-extended to 64 bits.

A saturation flag for each element reports whether clamping altered the value, but only when condition recording is enabled. It depends on this element alone, and no accumulated summary overflow bit feeds into it. If saturation is requested together with the overflow-enable option, the block signals an illegal instruction instead of producing a result. Whenever saturation is requested, the block marks the carry outputs of the producing unit as undefined. The result is registered one cycle after a valid input, and the valid strobe travels with it.

Top module: `sat_clamp_unit`

## Requirements
- R1: With saturation requested and unsigned mode (`signedMode`=0), a result is clamped to 0..2^w-1 and zero-extended to 64 bits.
- R2: With saturation requested and signed mode (`signedMode`=1), a result is clamped to -2^(w-1)..2^(w-1)-1 and sign-extended to 64 bits.
- R3: `widthSel` encodes the destination width as 0=8, 1=16, 2=32, 3=64 bits. Every output bit above w is the extension bit: 0 in unsigned mode, bit w-1 in signed mode.
- R4: `outSatFlag` is 1 exactly when clamping changed the value and `recordEnable` was set with the element. With `recordEnable`=0 it is 0.
- R5: An element with both `satEnable` and `ovfEnable` set produces `outIllegal`=1, `outValue`=0 and `outSatFlag`=0.
- R6: `outCarryUndef` equals the `satEnable` that came with the element.
- R7: Outputs appear on the first clock edge after `inValid`, and `outValid` repeats `inValid` delayed by one cycle.
- R8: Without `satEnable`, the low w bits of the input pass through unclamped and are extended per `signedMode`, with `outSatFlag`=0.
- R9: During and right after reset, `outValid`, `outSatFlag`, `outIllegal` and `outCarryUndef` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Element present on the inputs |
| inResult | input | 66 | Signed intermediate result |
| widthSel | input | 2 | Destination width code (0=8,1=16,2=32,3=64) |
| signedMode | input | 1 | 1 = signed range, 0 = unsigned range |
| satEnable | input | 1 | Saturation requested |
| recordEnable | input | 1 | Condition recording enabled |
| ovfEnable | input | 1 | Overflow-enable option of the instruction |
| outValid | output | 1 | Registered result valid |
| outValue | output | 64 | Clamped and extended element |
| outSatFlag | output | 1 | Element saturated (with recording) |
| outIllegal | output | 1 | Illegal saturate/overflow-enable combination |
| outCarryUndef | output | 1 | Carry outputs are undefined for this element |

## Verification
A wrong bound, or a width or sign decode that selects the wrong range, shows up on `outValue` in the very next cycle for any input just beyond the range limit. A flag computed from the wrong comparison or gated by the wrong strobe shows up on `outSatFlag` in that same cycle. Because the block holds no state beyond one register stage, any fault is visible one cycle after the element that triggers it. The bench therefore sweeps every width and sign mode across the bounds, the values next to them and the 66-bit extremes.

// File: rtl/sat_clamp_pkg.sv
package sat_clamp_pkg;
  localparam int NUM_EW = 4;
  localparam int SEL_W = $clog2(NUM_EW);
  localparam int BASE_W = 8;
  localparam int IN_W = 66;
  localparam int OUT_W = 64;

  typedef enum logic [SEL_W-1:0] {EW8, EW16, EW32, EW64} elemWidth_e;

  typedef struct packed {
    logic       load;
    logic       doClamp;
    logic       signedRange;
    logic       recordFlag;
    logic       trap;
    logic       carryUndef;
    elemWidth_e widthIdx;
  } clampCtrl_t;
endpackage

// File: rtl/sat_clamp_ctrl.sv
module sat_clamp_ctrl
  import sat_clamp_pkg::*;
(
  input  logic             inValid,
  input  logic [SEL_W-1:0] widthSel,
  input  logic             signedMode,
  input  logic             satEnable,
  input  logic             recordEnable,
  input  logic             ovfEnable,
  output clampCtrl_t       strobes
);
  always_comb begin
    strobes.load        = inValid;
    strobes.trap        = satEnable & ovfEnable;
    strobes.doClamp     = satEnable & ~ovfEnable;
    strobes.signedRange = signedMode;
    strobes.recordFlag  = recordEnable & satEnable & ~ovfEnable;
    strobes.carryUndef  = satEnable;
    strobes.widthIdx    = elemWidth_e'(widthSel);
  end
endmodule

// File: rtl/sat_clamp_dp.sv
module sat_clamp_dp
  import sat_clamp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  clampCtrl_t      strobes,
  input  logic [IN_W-1:0] inResult,
  output logic            outValid,
  output logic [OUT_W-1:0] outValue,
  output logic            outSatFlag,
  output logic            outIllegal,
  output logic            outCarryUndef
);
  localparam logic [IN_W-1:0] ONE = IN_W'(1);

  logic [OUT_W-1:0] candVal [NUM_EW];
  logic             candSat [NUM_EW];
  logic [SEL_W-1:0] widthQ;
  logic             signedQ;

  for (genvar g = 0; g < NUM_EW; g++) begin : g_width
    localparam int W = BASE_W << g;
    localparam logic [IN_W-1:0] HI_U = (ONE << W) - ONE;
    localparam logic [IN_W-1:0] LO_U = '0;
    localparam logic [IN_W-1:0] HI_S = (ONE << (W - 1)) - ONE;
    localparam logic [IN_W-1:0] LO_S = ~(ONE << (W - 1)) + ONE;

    logic [IN_W-1:0] hiBound, loBound, picked;
    logic            overHi, underLo;
    logic [W-1:0]    lowBits;

    always_comb begin
      hiBound = strobes.signedRange ? HI_S : HI_U;
      loBound = strobes.signedRange ? LO_S : LO_U;
      overHi  = $signed(inResult) > $signed(hiBound);
      underLo = $signed(inResult) < $signed(loBound);
      if (strobes.doClamp && overHi)       picked = hiBound;
      else if (strobes.doClamp && underLo) picked = loBound;
      else                                 picked = inResult;
      lowBits = picked[W-1:0];
      candSat[g] = strobes.doClamp & (overHi | underLo);
    end

    if (W >= OUT_W) begin : g_full
      assign candVal[g] = lowBits[OUT_W-1:0];
    end else begin : g_ext
      assign candVal[g] = {{(OUT_W-W){strobes.signedRange & lowBits[W-1]}}, lowBits};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid      <= 1'b0;
      outValue      <= '0;
      outSatFlag    <= 1'b0;
      outIllegal    <= 1'b0;
      outCarryUndef <= 1'b0;
      widthQ        <= '0;
      signedQ       <= 1'b0;
    end else begin
      outValid      <= strobes.load;
      outValue      <= strobes.trap ? '0 : candVal[strobes.widthIdx];
      outSatFlag    <= strobes.load & strobes.recordFlag & candSat[strobes.widthIdx];
      outIllegal    <= strobes.load & strobes.trap;
      outCarryUndef <= strobes.load & strobes.carryUndef;
      widthQ        <= strobes.widthIdx;
      signedQ       <= strobes.signedRange;
    end
  end

  // R7: valid follows input one cycle later
  a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> outValid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> !outValid);
  // R5: trap yields zero value and no flag
  a_r5_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    outIllegal |-> (outValue == '0) && !outSatFlag);
  // R1/R3: unsigned 8-bit result has zero upper bits
  a_r1_unsigned_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outIllegal && !signedQ && widthQ == SEL_W'(0)) |-> (outValue[OUT_W-1:BASE_W] == '0));
  // R2/R3: signed 8-bit result is a sign extension
  a_r2_signed_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && signedQ && widthQ == SEL_W'(0)) |->
      ($countones(outValue[OUT_W-1:BASE_W-1]) == 0 || $countones(outValue[OUT_W-1:BASE_W-1]) == OUT_W-BASE_W+1));
  // R4: no flag without a saturation request
  a_r4_flag_needs_sat: assert property (@(posedge clk) disable iff (!rst_n)
    outSatFlag |-> outCarryUndef);
endmodule

// File: rtl/sat_clamp_unit.sv
module sat_clamp_unit
  import sat_clamp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [IN_W-1:0]     inResult,
  input  logic [SEL_W-1:0]    widthSel,
  input  logic                signedMode,
  input  logic                satEnable,
  input  logic                recordEnable,
  input  logic                ovfEnable,
  output logic                outValid,
  output logic [OUT_W-1:0]    outValue,
  output logic                outSatFlag,
  output logic                outIllegal,
  output logic                outCarryUndef
);
  clampCtrl_t strobes;

  sat_clamp_ctrl u_ctrl (
    .inValid(inValid), .widthSel(widthSel), .signedMode(signedMode),
    .satEnable(satEnable), .recordEnable(recordEnable), .ovfEnable(ovfEnable),
    .strobes(strobes)
  );

  sat_clamp_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .inResult(inResult),
    .outValid(outValid), .outValue(outValue), .outSatFlag(outSatFlag),
    .outIllegal(outIllegal), .outCarryUndef(outCarryUndef)
  );

  // R6: carry-undefined marker tracks the saturation request
  a_r6_carry_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && satEnable) |=> outCarryUndef);
  // R5: illegal combination raises the trap
  a_r5_trap_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && satEnable && ovfEnable) |=> outIllegal);
  // R4: recording off means no flag
  a_r4_record_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !recordEnable) |=> !outSatFlag);
endmodule

// File: tb/sat_clamp_unit_bench.sv
module sat_clamp_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [65:0] inResult = '0;
  logic [1:0] widthSel = '0;
  logic signedMode = 1'b0, satEnable = 1'b0, recordEnable = 1'b0, ovfEnable = 1'b0;
  logic outValid, outSatFlag, outIllegal, outCarryUndef;
  logic [63:0] outValue;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sat_clamp_unit u_sat_clamp_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inResult(inResult),
    .widthSel(widthSel), .signedMode(signedMode), .satEnable(satEnable),
    .recordEnable(recordEnable), .ovfEnable(ovfEnable), .outValid(outValid),
    .outValue(outValue), .outSatFlag(outSatFlag), .outIllegal(outIllegal),
    .outCarryUndef(outCarryUndef)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected value from the range rules, in 68-bit arithmetic
  function automatic logic [63:0] model(input logic [65:0] v, input int w, input bit sg,
                                        input bit sat, output bit clipped);
    logic signed [67:0] x, hi, lo, r;
    logic [63:0] o;
    x = {{2{v[65]}}, v};
    hi = sg ? ((68'sd1 <<< (w - 1)) - 68'sd1) : ((68'sd1 <<< w) - 68'sd1);
    lo = sg ? -(68'sd1 <<< (w - 1)) : 68'sd0;
    r = x;
    clipped = 0;
    if (sat && x > hi) begin r = hi; clipped = 1; end
    if (sat && x < lo) begin r = lo; clipped = 1; end
    for (int b = 0; b < 64; b++) o[b] = (b < w) ? r[b] : (sg ? r[w-1] : 1'b0);
    return o;
  endfunction

  task automatic runOne(input logic [65:0] v, input int wsel, input bit sg, input bit sat,
                        input bit rec, input bit ovf);
    bit clipped;
    logic [63:0] expV;
    int w;
    string tag;
    w = 8 << wsel;
    expV = model(v, w, sg, sat, clipped);
    @(negedge clk);
    inValid = 1; inResult = v; widthSel = 2'(wsel); signedMode = sg;
    satEnable = sat; recordEnable = rec; ovfEnable = ovf;
    @(negedge clk);
    inValid = 0;
    tag = !sat ? "R8/R3 value" : (sg ? "R2/R3 value" : "R1/R3 value");
    check("R7 outValid", 64'(outValid), 64'd1);
    if (sat && ovf) begin
      check("R5 illegal", 64'(outIllegal), 64'd1);
      check("R5 value zero", outValue, 64'd0);
      check("R5 flag", 64'(outSatFlag), 64'd0);
    end else begin
      check(tag, outValue, expV);
      check(sat ? "R4 flag" : "R8 flag", 64'(outSatFlag), 64'(clipped & rec & sat));
      check("R5 no illegal", 64'(outIllegal), 64'd0);
    end
    check("R6 carry undef", 64'(outCarryUndef), 64'(sat));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [65:0] lfsr;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 outValid", 64'(outValid), 64'd0);
    check("R9 outSatFlag", 64'(outSatFlag), 64'd0);
    check("R9 outIllegal", 64'(outIllegal), 64'd0);
    check("R9 outCarryUndef", 64'(outCarryUndef), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R7 idle valid", 64'(outValid), 64'd0);

    lfsr = 66'h2_1234_5678_9ABC_DEF1;
    for (int ws = 0; ws < 4; ws++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int sat = 0; sat < 2; sat++) begin
          logic signed [65:0] hi, lo;
          int w;
          w = 8 << ws;
          hi = sg ? ((66'sd1 <<< (w - 1)) - 66'sd1) : ((66'sd1 <<< w) - 66'sd1);
          lo = sg ? -(66'sd1 <<< (w - 1)) : 66'sd0;
          runOne(hi, ws, sg, sat, 1, 0);
          runOne(hi + 66'sd1, ws, sg, sat, 1, 0);
          runOne(hi - 66'sd1, ws, sg, sat, 1, 0);
          runOne(lo, ws, sg, sat, 1, 0);
          runOne(lo - 66'sd1, ws, sg, sat, 1, 0);
          runOne(lo + 66'sd1, ws, sg, sat, 1, 0);
          runOne(66'd0, ws, sg, sat, 1, 0);
          runOne({66{1'b1}}, ws, sg, sat, 1, 0);
          runOne({1'b0, {65{1'b1}}}, ws, sg, sat, 1, 0);
          runOne({1'b1, 65'd0}, ws, sg, sat, 1, 0);
          runOne(hi + 66'sd1, ws, sg, sat, 0, 0);   // R4 recording off
          for (int k = 0; k < 12; k++) begin
            lfsr = {lfsr[64:0], lfsr[65] ^ lfsr[64] ^ lfsr[55] ^ lfsr[3]};
            runOne(lfsr >>> (k * 5), ws, sg, sat, k[0], 0);
          end
          runOne(hi + 66'sd5, ws, sg, 1, 1, 1);     // R5 trap
          runOne(66'd3, ws, sg, 0, 1, 1);           // ovf without sat is legal
        end
      end
    end
    @(negedge clk);
    check("R7 valid drops", 64'(outValid), 64'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule